// File: doc/BRIEF.md
# Bucket-Partitioned Receive Queue

This block is the receive side of a station on a credit-based message ring. One shared message store of `DEPTH` entries is divided into up to `NUM_BKT` independent circular queues (buckets). Software programs a size for every bucket. The buckets are packed in index order, so each bucket's region begins where the previous one ends. An incoming message names its bucket and is appended at that bucket's tail. A consumer pops from a bucket it selects. Every successful pop returns the oldest entry of that bucket and sends a one-cycle credit pulse, tagged with the bucket index, back toward the ring.

A layout is accepted only when every nonzero size is a power of two, each bucket's start offset is a whole multiple of its own size, and the sizes sum to no more than the store depth. A rejected layout raises an error flag and disables every bucket. A size of zero is a legal, disabled bucket. Senders are expected to keep within their credits. Any write that still finds no room is dropped and recorded in a per-bucket sticky flag.

Top module: `seg_rxq`

## Requirements
- R1: During and after reset, every bucket has size zero, and `cfg_err_o`, `ovf_o`, `rd_vld_o` and `crd_vld_o` are all low.
- R2: A cycle with `cfg_load_i` high captures `cfg_size_i`, where bucket i's size is bits [i*SZ_W +: SZ_W]. That cycle also empties every bucket and clears `ovf_o`. A write or pop presented in the same cycle is ignored and sets no flag. Bucket i starts at the sum of the sizes of buckets 0..i-1.
- R3: From the cycle after a load, `cfg_err_o` is high exactly when the layout is illegal. A layout is illegal if some nonzero size is not a power of two, or its start is not a multiple of it, or the sizes total more than `DEPTH`. While `cfg_err_o` is high, every bucket behaves as a zero-size bucket.
- R4: A write to a zero-size bucket is dropped and sets that bucket's bit in `ovf_o`.
- R5: A write to a bucket with room is stored. Pops from a bucket return its entries in write order, unaffected by traffic to other buckets.
- R6: A bucket holds exactly its programmed size. A write to a full bucket is dropped, sets its `ovf_o` bit and leaves its stored entries intact.
- R7: An `ovf_o` bit stays high until the next configuration load.
- R8: A pop request to a nonempty bucket yields `rd_vld_o` high, with the entry on `rd_data_o`, in the cycle after the request.
- R9: A pop request to an empty bucket yields `rd_vld_o` low and no credit pulse.
- R10: Each successful pop produces a one-cycle `crd_vld_o` pulse in the cycle after the request, with `crd_bkt_o` equal to the popped bucket index.
- R11: Room and emptiness are judged on the occupancy at the start of the cycle. A write and a pop to the same bucket in one cycle both take effect when it is nonempty and not full. When it is full, the pop succeeds and the write is dropped.
- R12: A bucket wraps within its own region indefinitely without disturbing the entries of any other bucket.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_load_i | input | 1 | Capture bucket sizes and empty all buckets |
| cfg_size_i | input | NUM_BKT*SZ_W | Packed bucket sizes, bucket i at [i*SZ_W +: SZ_W] |
| cfg_err_o | output | 1 | Current layout is illegal |
| wr_vld_i | input | 1 | Incoming message valid |
| wr_bkt_i | input | BKT_W | Destination bucket of incoming message |
| wr_data_i | input | DATA_W | Incoming message payload |
| rd_req_i | input | 1 | Pop request |
| rd_bkt_i | input | BKT_W | Bucket to pop from |
| rd_vld_o | output | 1 | Popped entry valid |
| rd_data_o | output | DATA_W | Popped entry |
| crd_vld_o | output | 1 | Credit-return pulse |
| crd_bkt_o | output | BKT_W | Bucket the credit belongs to |
| ovf_o | output | NUM_BKT | Sticky per-bucket dropped-write flags |

## Verification
The bench builds the block with `DEPTH=32`, `NUM_BKT=4` and `DATA_W=16`. At that size, every layout drawn from the sizes {0,1,2,3,4,8,16,32} can be tried: 4096 layouts that mix legal, misaligned, non-power-of-two and oversubscribed cases. The legality flag is compared against an arithmetic model for each of them. Every fourth legal layout is filled one entry past capacity in every bucket and then drained, which exercises full, empty, zero-size and credit behaviour across many region placements. Directed cases then cover same-cycle write and pop, writes during a load, long wrap runs and flag stickiness.

// File: rtl/seg_rxq_pkg.sv
package seg_rxq_pkg;

  // true when v is zero or a power of two
  function automatic logic zero_or_pow2(input logic [31:0] v);
    return (v & (v - 32'd1)) == 32'd0;
  endfunction

  // true when start is a multiple of a power-of-two size (size zero always passes)
  function automatic logic start_aligned(input logic [31:0] start, input logic [31:0] size);
    return (size == 32'd0) || ((start & (size - 32'd1)) == 32'd0);
  endfunction

endpackage

// File: rtl/seg_rxq_cfg.sv
module seg_rxq_cfg
  import seg_rxq_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int NUM_BKT = 8,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int SZ_W   = PTR_W + 1,
  localparam int SUM_W  = SZ_W + $clog2(NUM_BKT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic [NUM_BKT*SZ_W-1:0] sizes_i,
  output logic [PTR_W-1:0]        start_o [NUM_BKT],
  output logic [PTR_W-1:0]        mask_o  [NUM_BKT],
  output logic [SZ_W-1:0]         size_o  [NUM_BKT],
  output logic [NUM_BKT-1:0]      en_o,
  output logic                    err_o
);

  logic [SZ_W-1:0]    size_q [NUM_BKT];
  logic [SUM_W-1:0]   base_w [NUM_BKT];
  logic [NUM_BKT-1:0] legal_w;
  logic [SUM_W-1:0]   total_w;
  logic               ok_w;

  // size registers, written only on a load
  for (genvar i = 0; i < NUM_BKT; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        size_q[i] <= '0;
      end else if (load_i) begin
        size_q[i] <= sizes_i[i*SZ_W +: SZ_W];
      end
    end
  end

  // running sum of lower bucket sizes gives each start offset
  assign base_w[0] = '0;
  for (genvar i = 1; i < NUM_BKT; i++) begin : g_base
    assign base_w[i] = base_w[i-1] + SUM_W'(size_q[i-1]);
  end
  assign total_w = base_w[NUM_BKT-1] + SUM_W'(size_q[NUM_BKT-1]);

  for (genvar i = 0; i < NUM_BKT; i++) begin : g_chk
    assign legal_w[i] = zero_or_pow2(32'(size_q[i])) &&
                        start_aligned(32'(base_w[i]), 32'(size_q[i]));
    assign start_o[i] = PTR_W'(base_w[i]);
    assign mask_o[i]  = PTR_W'(size_q[i] - SZ_W'(1));
    assign size_o[i]  = size_q[i];
    assign en_o[i]    = ok_w && (size_q[i] != '0);
  end

  assign ok_w  = (&legal_w) && (total_w <= SUM_W'(DEPTH));
  assign err_o = !ok_w;

endmodule

// File: rtl/seg_rxq_lane.sv
module seg_rxq_lane #(
  parameter int DEPTH  = 256,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int SZ_W  = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [SZ_W-1:0]  size_i,
  input  logic [PTR_W-1:0] mask_i,
  input  logic             push_i,
  input  logic             pop_i,
  output logic             accept_o,
  output logic             grant_o,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic             ovf_o
);

  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [SZ_W-1:0]  cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             upd_w;

  // room and emptiness both judged on the start-of-cycle count
  assign accept_o = push_i && en_i && (cnt_q != size_i);
  assign grant_o  = pop_i && (cnt_q != '0);
  assign upd_w    = clr_i || push_i || pop_i;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    ovf_d  = ovf_q;
    if (clr_i) begin
      head_d = '0;
      tail_d = '0;
      cnt_d  = '0;
      ovf_d  = 1'b0;
    end else begin
      if (accept_o) tail_d = (tail_q + PTR_W'(1)) & mask_i;
      if (grant_o)  head_d = (head_q + PTR_W'(1)) & mask_i;
      cnt_d = cnt_q + SZ_W'(accept_o) - SZ_W'(grant_o);
      if (push_i && !accept_o) ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else if (upd_w) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign ovf_o  = ovf_q;

  // R6: occupancy never passes the programmed size
  assert_cnt_le_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= size_i);

  // R7: a raised drop flag only falls on a load
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_i) |=> ovf_q);

  // R3: a disabled bucket holds nothing
  assert_disabled_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (cnt_q == '0));

endmodule

// File: rtl/seg_rxq_mem.sv
module seg_rxq_mem #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [AW-1:0]     wa_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic              re_i,
  input  logic [AW-1:0]     ra_i,
  output logic [DATA_W-1:0] rd_o
);

  logic [DATA_W-1:0] store_q [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we_i) store_q[wa_i] <= wd_i;
    if (re_i) rd_q <= store_q[ra_i];
  end

  assign rd_o = rd_q;

endmodule

// File: rtl/seg_rxq.sv
module seg_rxq #(
  parameter int DEPTH   = 256,
  parameter int NUM_BKT = 8,   // power of two, at least 2
  parameter int DATA_W  = 64,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int SZ_W   = PTR_W + 1,
  localparam int BKT_W  = $clog2(NUM_BKT)
) (
  input  logic                    clk,
  input  logic                    rst_n_i,
  input  logic                    cfg_load_i,
  input  logic [NUM_BKT*SZ_W-1:0] cfg_size_i,
  output logic                    cfg_err_o,
  input  logic                    wr_vld_i,
  input  logic [BKT_W-1:0]        wr_bkt_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic                    rd_req_i,
  input  logic [BKT_W-1:0]        rd_bkt_i,
  output logic                    rd_vld_o,
  output logic [DATA_W-1:0]       rd_data_o,
  output logic                    crd_vld_o,
  output logic [BKT_W-1:0]        crd_bkt_o,
  output logic [NUM_BKT-1:0]      ovf_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_n;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) rsync_q <= '0;
    else          rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  logic [PTR_W-1:0]   start_w [NUM_BKT];
  logic [PTR_W-1:0]   mask_w  [NUM_BKT];
  logic [SZ_W-1:0]    size_w  [NUM_BKT];
  logic [PTR_W-1:0]   head_w  [NUM_BKT];
  logic [PTR_W-1:0]   tail_w  [NUM_BKT];
  logic [NUM_BKT-1:0] en_w, push_w, pop_w, acc_w, gnt_w;

  seg_rxq_cfg #(.DEPTH(DEPTH), .NUM_BKT(NUM_BKT)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (cfg_load_i),
    .sizes_i (cfg_size_i),
    .start_o (start_w),
    .mask_o  (mask_w),
    .size_o  (size_w),
    .en_o    (en_w),
    .err_o   (cfg_err_o)
  );

  for (genvar i = 0; i < NUM_BKT; i++) begin : g_lane
    assign push_w[i] = wr_vld_i && (wr_bkt_i == BKT_W'(i)) && !cfg_load_i;
    assign pop_w[i]  = rd_req_i && (rd_bkt_i == BKT_W'(i)) && !cfg_load_i;

    seg_rxq_lane #(.DEPTH(DEPTH)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (cfg_load_i),
      .en_i     (en_w[i]),
      .size_i   (size_w[i]),
      .mask_i   (mask_w[i]),
      .push_i   (push_w[i]),
      .pop_i    (pop_w[i]),
      .accept_o (acc_w[i]),
      .grant_o  (gnt_w[i]),
      .head_o   (head_w[i]),
      .tail_o   (tail_w[i]),
      .ovf_o    (ovf_o[i])
    );
  end

  // address selection: at most one lane accepts and one lane grants
  logic [PTR_W-1:0] wa_w, ra_w;
  logic             we_w, re_w;

  always_comb begin
    wa_w = '0;
    ra_w = '0;
    for (int i = 0; i < NUM_BKT; i++) begin
      if (acc_w[i]) wa_w = wa_w | start_w[i] | tail_w[i];
      if (gnt_w[i]) ra_w = ra_w | start_w[i] | head_w[i];
    end
  end
  assign we_w = |acc_w;
  assign re_w = |gnt_w;

  seg_rxq_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
    .clk  (clk),
    .we_i (we_w),
    .wa_i (wa_w),
    .wd_i (wr_data_i),
    .re_i (re_w),
    .ra_i (ra_w),
    .rd_o (rd_data_o)
  );

  // pop response and credit-return pulse
  logic             vld_q, vld_d;
  logic [BKT_W-1:0] cbkt_q;

  assign vld_d = re_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cbkt_q <= '0;
    else if (re_w) cbkt_q <= rd_bkt_i;
  end

  assign rd_vld_o  = vld_q;
  assign crd_vld_o = vld_q;
  assign crd_bkt_o = cbkt_q;

  // R5: a single message lands in at most one bucket
  assert_one_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_w));

  // R8: at most one bucket is popped per cycle
  assert_one_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_w));

  // R10: a credit only follows a pop request to the same bucket
  assert_credit_after_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    crd_vld_o |-> ($past(rd_req_i) && (crd_bkt_o == $past(rd_bkt_i))));

  // R2: no write is accepted while a layout is being loaded
  assert_load_blocks_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load_i |-> !we_w);

endmodule

// File: tb/sim_seg_rxq.sv
module sim_seg_rxq;

  localparam int D    = 32;
  localparam int NB   = 4;
  localparam int DW   = 16;
  localparam int SZW  = $clog2(D) + 1;
  localparam int BW   = $clog2(NB);

  logic              clk = 1'b0;
  logic              rst_n_i;
  logic              cfg_load_i;
  logic [NB*SZW-1:0] cfg_size_i;
  logic              cfg_err_o;
  logic              wr_vld_i;
  logic [BW-1:0]     wr_bkt_i;
  logic [DW-1:0]     wr_data_i;
  logic              rd_req_i;
  logic [BW-1:0]     rd_bkt_i;
  logic              rd_vld_o;
  logic [DW-1:0]     rd_data_o;
  logic              crd_vld_o;
  logic [BW-1:0]     crd_bkt_o;
  logic [NB-1:0]     ovf_o;

  always #5 clk = ~clk;

  seg_rxq #(.DEPTH(D), .NUM_BKT(NB), .DATA_W(DW)) u0 (.*);

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int sz [NB];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int pick(input int k);
    case (k)
      0: return 0;  1: return 1;  2: return 2;  3: return 3;
      4: return 4;  5: return 8;  6: return 16; default: return 32;
    endcase
  endfunction

  function automatic bit legal();
    int base = 0;
    for (int i = 0; i < NB; i++) begin
      if (sz[i] != 0) begin
        if ((sz[i] & (sz[i] - 1)) != 0) return 1'b0;
        if ((base % sz[i]) != 0) return 1'b0;
      end
      base += sz[i];
    end
    return base <= D;
  endfunction

  function automatic logic [DW-1:0] dval(input int c, input int b, input int k);
    return DW'(c * 37 + b * 1000 + k * 3);
  endfunction

  // all tasks start and end at a falling edge
  task automatic load_cfg(input bit with_write);
    for (int i = 0; i < NB; i++) cfg_size_i[i*SZW +: SZW] = SZW'(sz[i]);
    cfg_load_i = 1'b1;
    wr_vld_i   = with_write;
    wr_bkt_i   = '0;
    wr_data_i  = 16'hDEAD;
    @(negedge clk);
    cfg_load_i = 1'b0;
    wr_vld_i   = 1'b0;
  endtask

  task automatic push(input int b, input logic [DW-1:0] d);
    wr_vld_i  = 1'b1;
    wr_bkt_i  = BW'(b);
    wr_data_i = d;
    @(negedge clk);
    wr_vld_i  = 1'b0;
  endtask

  task automatic pop_chk(input int b, input bit exp_v, input logic [DW-1:0] exp_d,
                         input string req);
    rd_req_i = 1'b1;
    rd_bkt_i = BW'(b);
    @(negedge clk);
    rd_req_i = 1'b0;
    if (exp_v)
      chk(rd_vld_o && crd_vld_o && crd_bkt_o == BW'(b) && rd_data_o == exp_d, req,
          $sformatf("pop bucket %0d vld/crd/crdbkt/data", b),
          {rd_vld_o, crd_vld_o, crd_bkt_o, rd_data_o}, {2'b11, BW'(b), exp_d});
    else
      chk(!rd_vld_o && !crd_vld_o, req, $sformatf("empty pop bucket %0d vld/crd", b),
          {rd_vld_o, crd_vld_o}, 0);
  endtask

  task automatic push_pop(input int b, input logic [DW-1:0] d, input logic [DW-1:0] exp_d,
                          input string req);
    wr_vld_i  = 1'b1;
    wr_bkt_i  = BW'(b);
    wr_data_i = d;
    rd_req_i  = 1'b1;
    rd_bkt_i  = BW'(b);
    @(negedge clk);
    wr_vld_i  = 1'b0;
    rd_req_i  = 1'b0;
    chk(rd_vld_o && crd_vld_o && rd_data_o == exp_d, req, "same-cycle pop data",
        rd_data_o, exp_d);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int vcount = 0;
    rst_n_i = 1'b0; cfg_load_i = 1'b0; cfg_size_i = '0;
    wr_vld_i = 1'b0; wr_bkt_i = '0; wr_data_i = '0;
    rd_req_i = 1'b0; rd_bkt_i = '0;
    repeat (3) @(negedge clk);
    // R1: state while held in reset
    chk(!cfg_err_o && ovf_o == '0 && !rd_vld_o && !crd_vld_o, "R1", "outputs in reset",
        {cfg_err_o, ovf_o, rd_vld_o, crd_vld_o}, 0);
    rst_n_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(!cfg_err_o && ovf_o == '0 && !rd_vld_o && !crd_vld_o, "R1", "outputs after reset",
        {cfg_err_o, ovf_o, rd_vld_o, crd_vld_o}, 0);
    // R1: every bucket is zero-size after reset, so a write is dropped
    push(2, 16'h1234);
    chk(ovf_o == 4'b0100, "R1", "write after reset dropped", ovf_o, 4'b0100);
    pop_chk(2, 1'b0, '0, "R1");

    // sweep all layouts from an eight-value size set
    for (int c = 0; c < 4096; c++) begin
      for (int i = 0; i < NB; i++) sz[i] = pick((c >> (3 * i)) & 7);
      load_cfg(1'b0);
      chk(cfg_err_o == !legal(), "R3", $sformatf("layout %0d error flag", c),
          cfg_err_o, !legal());
      if (!legal()) begin
        // R3: rejected layout disables all buckets
        push(0, dval(c, 0, 0));
        chk(ovf_o == 4'b0001, "R3", "write to rejected layout", ovf_o, 1);
        pop_chk(0, 1'b0, '0, "R3");
      end else begin
        vcount++;
        if ((vcount % 4) == 0) begin
          // R6/R4: one write past capacity in every bucket
          for (int b = 0; b < NB; b++)
            for (int k = 0; k <= sz[b]; k++) push(b, dval(c, b, k));
          chk(ovf_o == 4'b1111, "R6", "every bucket over capacity", ovf_o, 15);
          // R5/R8/R10: drain in order, then R9 on empty
          for (int b = 0; b < NB; b++) begin
            for (int k = 0; k < sz[b]; k++) pop_chk(b, 1'b1, dval(c, b, k), "R5");
            pop_chk(b, 1'b0, '0, "R9");
          end
        end
      end
    end

    // directed layout: sizes 4,4,8,16 at starts 0,4,8,16
    sz[0] = 4; sz[1] = 4; sz[2] = 8; sz[3] = 16;
    load_cfg(1'b1);  // R2: write in load cycle ignored
    chk(!cfg_err_o && ovf_o == '0, "R2", "load with write: no error, no drop flag",
        {cfg_err_o, ovf_o}, 0);
    pop_chk(0, 1'b0, '0, "R2");

    // R11: same-cycle write and pop on nonempty bucket
    push(1, 16'h0A01);
    push_pop(1, 16'h0A02, 16'h0A01, "R11");
    pop_chk(1, 1'b1, 16'h0A02, "R11");
    pop_chk(1, 1'b0, '0, "R11");
    chk(ovf_o == '0, "R11", "no drop on nonfull write+pop", ovf_o, 0);

    // R11: full bucket, same-cycle write and pop: pop wins, write dropped
    for (int k = 0; k < 4; k++) push(0, DW'(16'h0B00 + k));
    push_pop(0, 16'h0BFF, 16'h0B00, "R11");
    chk(ovf_o == 4'b0001, "R11", "write to full bucket dropped", ovf_o, 1);
    for (int k = 1; k < 4; k++) pop_chk(0, 1'b1, DW'(16'h0B00 + k), "R11");
    pop_chk(0, 1'b0, '0, "R11");

    // R12: long wrap in bucket 2 with neighbours holding data
    push(1, 16'h0C01);
    push(3, 16'h0C03);
    for (int k = 0; k < 3; k++) push(2, DW'(16'h0D00 + k));
    for (int k = 3; k < 40; k++) push_pop(2, DW'(16'h0D00 + k), DW'(16'h0D00 + k - 3), "R12");
    for (int k = 37; k < 40; k++) pop_chk(2, 1'b1, DW'(16'h0D00 + k), "R12");
    pop_chk(1, 1'b1, 16'h0C01, "R12");
    pop_chk(3, 1'b1, 16'h0C03, "R12");

    // R7: flag from earlier drop still high after many good operations
    chk(ovf_o == 4'b0001, "R7", "sticky drop flag", ovf_o, 1);
    load_cfg(1'b0);
    chk(ovf_o == '0, "R2", "load clears drop flags", ovf_o, 0);

    // R4: zero-size bucket between legal ones
    sz[0] = 8; sz[1] = 0; sz[2] = 8; sz[3] = 16;
    load_cfg(1'b0);
    chk(!cfg_err_o, "R3", "zero-size bucket layout legal", cfg_err_o, 0);
    push(1, 16'h0E01);
    chk(ovf_o == 4'b0010, "R4", "write to zero-size bucket", ovf_o, 2);
    pop_chk(1, 1'b0, '0, "R4");
    push(2, 16'h0E02);
    pop_chk(2, 1'b1, 16'h0E02, "R5");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule